// File: doc/BRIEF.md
# UART Receive Status Flags

This block keeps the error and condition flags of a UART receiver and shows them through two read-only status words. The receiver sends single-cycle event strobes: a stop bit sampled as 0, a parity mismatch, a completed character, and a detected break. Each strobe sets its flag on the next clock edge. A flag stays set until software reads the primary status word while the flag is set and then reads the receive data register. Reset also clears every flag. A break sets the break flag, the framing flag and the receive-full flag together. In nine-bit character mode it also gives a one-cycle pulse that clears the stored ninth data bit.

The secondary status word carries the break flag and a live copy of the reception-in-progress level. The block drives one error interrupt request from the framing and parity flags, each gated by its own enable. The break flag never raises an interrupt by itself. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset all flags are 0, both status words read 0x00 and `err_irq` is 0.
- R2: The primary status word holds receive-full at bit 5, framing error at bit 1 and parity error at bit 0, with the other bits at 0. `data_ready_evt`, `stop_zero_evt` and `parity_err_evt` each set their flag, visible from the clock edge that samples the strobe.
- R3: A flag clears on the edge of a `rd_data` strobe only if an earlier `rd_stat1` strobe found it set. A `rd_data` with no such earlier primary read leaves it set. A flag that was 0 at the primary read and sets afterwards stays set through the data read.
- R4: A set strobe wins over a clear. If it arrives in the same cycle as a qualifying `rd_data`, or between the primary read and the data read, the flag stays set.
- R5: `err_irq` is high exactly when (framing flag and `fe_ie`) or (parity flag and `pe_ie`) holds. The break flag does not drive it.
- R6: `break_evt` sets the break flag, the framing flag and the receive-full flag on the same edge. The break flag clears by the same primary-read-then-data-read sequence.
- R7: `ninth_clr` is high in exactly the cycle in which `break_evt` is high while `nine_bit_mode` is 1, and is 0 otherwise.
- R8: The secondary status word holds the break flag at bit 1 and `rx_busy` at bit 0, with bits 7 to 2 at 0.
- R9: `rd_val` is combinational. It shows the primary word while `rd_stat1` is high, the secondary word while only `rd_stat2` is high, and 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_zero_evt | input | 1 | Strobe: stop bit sampled as 0 |
| parity_err_evt | input | 1 | Strobe: parity mismatch |
| data_ready_evt | input | 1 | Strobe: character moved to data register |
| break_evt | input | 1 | Strobe: break character detected |
| rx_busy | input | 1 | Level: reception in progress |
| nine_bit_mode | input | 1 | Nine-bit character mode selected |
| fe_ie | input | 1 | Framing error interrupt enable |
| pe_ie | input | 1 | Parity error interrupt enable |
| rd_stat1 | input | 1 | Read strobe, primary status word |
| rd_stat2 | input | 1 | Read strobe, secondary status word |
| rd_data | input | 1 | Read strobe, receive data register |
| rd_val | output | 8 | Read data of the selected status word |
| err_irq | output | 1 | Masked error interrupt request |
| ninth_clr | output | 1 | Pulse that clears the stored ninth data bit |

## Verification
An event strobe held through one rising edge shows in `rd_val` and `err_irq` right after that edge. A clear takes effect on the edge of the `rd_data` strobe, and the primary read that arms it must have had its own earlier edge. `rd_val` and `ninth_clr` are combinational, so they are due in the same cycle as the strobe that selects them. The bench changes inputs on the falling edge and samples 1 ns later, before the next rising edge. Each result is therefore read in the cycle in which it is due.

// File: rtl/uart_rx_flags_pkg.sv
package uart_rx_flags_pkg;
  localparam int NFLAG   = 4;
  localparam int IDX_PE  = 0;
  localparam int IDX_FE  = 1;
  localparam int IDX_BRK = 2;
  localparam int IDX_RDF = 3;
  localparam int WORD_W  = 8;
  typedef logic [NFLAG-1:0] flag_vec_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rxf_flag_cell.sv
module rxf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_o
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_i)
        flag_o <= 1'b1;
      else if (data_rd_i && armed_q)
        flag_o <= 1'b0;

      if (set_i)
        armed_q <= 1'b0;
      else if (stat_rd_i)
        armed_q <= flag_o;
      else if (data_rd_i)
        armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_read_mux.sv
module rxf_read_mux #(
  parameter int W = 8
) (
  input  logic         sel_a,
  input  logic         sel_b,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic [W-1:0] out_o
);
  always_comb begin
    if (sel_a)      out_o = word_a;
    else if (sel_b) out_o = word_b;
    else            out_o = '0;
  end
endmodule

// File: rtl/rxf_irq_gen.sv
module rxf_irq_gen (
  input  logic fe_flag,
  input  logic pe_flag,
  input  logic fe_en,
  input  logic pe_en,
  output logic irq_o
);
  assign irq_o = (fe_flag && fe_en) || (pe_flag && pe_en);
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_flags_pkg::*;
#(
  parameter int PRI_PE_BIT  = 0,
  parameter int PRI_FE_BIT  = 1,
  parameter int PRI_RDF_BIT = 5,
  parameter int SEC_BSY_BIT = 0,
  parameter int SEC_BRK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_zero_evt,
  input  logic              parity_err_evt,
  input  logic              data_ready_evt,
  input  logic              break_evt,
  input  logic              rx_busy,
  input  logic              nine_bit_mode,
  input  logic              fe_ie,
  input  logic              pe_ie,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  input  logic              rd_data,
  output logic [WORD_W-1:0] rd_val,
  output logic              err_irq,
  output logic              ninth_clr
);
  flag_vec_t set_vec;
  flag_vec_t flag_q;
  word_t     pri_word;
  word_t     sec_word;

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_PE]  = parity_err_evt;
    set_vec[IDX_FE]  = stop_zero_evt || break_evt;
    set_vec[IDX_BRK] = break_evt;
    set_vec[IDX_RDF] = data_ready_evt || break_evt;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rxf_flag_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec[i]),
      .stat_rd_i (rd_stat1),
      .data_rd_i (rd_data),
      .flag_o    (flag_q[i])
    );
  end

  always_comb begin
    pri_word              = '0;
    pri_word[PRI_PE_BIT]  = flag_q[IDX_PE];
    pri_word[PRI_FE_BIT]  = flag_q[IDX_FE];
    pri_word[PRI_RDF_BIT] = flag_q[IDX_RDF];
    sec_word              = '0;
    sec_word[SEC_BRK_BIT] = flag_q[IDX_BRK];
    sec_word[SEC_BSY_BIT] = rx_busy;
  end

  rxf_read_mux #(.W(WORD_W)) u_mux (
    .sel_a  (rd_stat1),
    .sel_b  (rd_stat2),
    .word_a (pri_word),
    .word_b (sec_word),
    .out_o  (rd_val)
  );

  rxf_irq_gen u_irq (
    .fe_flag (flag_q[IDX_FE]),
    .pe_flag (flag_q[IDX_PE]),
    .fe_en   (fe_ie),
    .pe_en   (pe_ie),
    .irq_o   (err_irq)
  );

  assign ninth_clr = break_evt && nine_bit_mode;
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk
  import uart_rx_flags_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stop_zero_evt,
  input logic              break_evt,
  input logic              nine_bit_mode,
  input logic              fe_ie,
  input logic              pe_ie,
  input logic              rd_stat1,
  input logic              rd_stat2,
  input logic              rd_data,
  input logic [WORD_W-1:0] rd_val,
  input logic              err_irq,
  input logic              ninth_clr,
  input flag_vec_t         flags
);
  a_r2_fe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    stop_zero_evt |=> flags[IDX_FE]);

  a_r3_no_clear_without_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data |=> ((flags & $past(flags)) == $past(flags)));

  a_r5_masked_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_ie && !pe_ie) |-> !err_irq);

  a_r6_break_forces: assert property (@(posedge clk) disable iff (!rst_n)
    break_evt |=> (flags[IDX_BRK] && flags[IDX_FE] && flags[IDX_RDF]));

  a_r7_ninth_only_on_break: assert property (@(posedge clk) disable iff (!rst_n)
    ninth_clr |-> (break_evt && nine_bit_mode));

  a_r8_sec_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat2 && !rd_stat1) |-> (rd_val[WORD_W-1:2] == '0));

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat1 && !rd_stat2) |-> (rd_val == '0));
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stop_zero_evt (stop_zero_evt),
  .break_evt     (break_evt),
  .nine_bit_mode (nine_bit_mode),
  .fe_ie         (fe_ie),
  .pe_ie         (pe_ie),
  .rd_stat1      (rd_stat1),
  .rd_stat2      (rd_stat2),
  .rd_data       (rd_data),
  .rd_val        (rd_val),
  .err_irq       (err_irq),
  .ninth_clr     (ninth_clr),
  .flags         (flag_q)
);

// File: tb/uart_rx_flags_tb.sv
`timescale 1ns/1ps
module uart_rx_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_zero_evt = 0, parity_err_evt = 0, data_ready_evt = 0, break_evt = 0;
  logic rx_busy = 0, nine_bit_mode = 0, fe_ie = 0, pe_ie = 0;
  logic rd_stat1 = 0, rd_stat2 = 0, rd_data = 0;
  logic [7:0] rd_val;
  logic err_irq, ninth_clr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_flags u_dut (
    .clk(clk), .rst_n(rst_n),
    .stop_zero_evt(stop_zero_evt), .parity_err_evt(parity_err_evt),
    .data_ready_evt(data_ready_evt), .break_evt(break_evt),
    .rx_busy(rx_busy), .nine_bit_mode(nine_bit_mode),
    .fe_ie(fe_ie), .pe_ie(pe_ie),
    .rd_stat1(rd_stat1), .rd_stat2(rd_stat2), .rd_data(rd_data),
    .rd_val(rd_val), .err_irq(err_irq), .ninth_clr(ninth_clr)
  );

  // vector: events {data_ready,break,stop_zero,parity}, enables {fe_ie,pe_ie},
  // expected primary word, expected err_irq
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {4'b0001, 2'b01, 8'h01, 1'b1},
    {4'b0010, 2'b01, 8'h02, 1'b0},
    {4'b0010, 2'b10, 8'h02, 1'b1},
    {4'b0100, 2'b11, 8'h22, 1'b1},
    {4'b1000, 2'b11, 8'h20, 1'b0},
    {4'b0011, 2'b00, 8'h03, 1'b0},
    {4'b0000, 2'b11, 8'h00, 1'b0}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire(logic [3:0] e);
    {data_ready_evt, break_evt, stop_zero_evt, parity_err_evt} = e;
    tick();
    {data_ready_evt, break_evt, stop_zero_evt, parity_err_evt} = 4'b0;
  endtask

  task automatic rd_pri(string tag, logic [7:0] exp);
    rd_stat1 = 1'b1;
    #1 chk(tag, rd_val, exp);
    tick();
    rd_stat1 = 1'b0;
  endtask

  task automatic rd_sec(string tag, logic [7:0] exp);
    rd_stat2 = 1'b1;
    #1 chk(tag, rd_val, exp);
    tick();
    rd_stat2 = 1'b0;
  endtask

  task automatic rd_dat();
    rd_data = 1'b1;
    tick();
    rd_data = 1'b0;
  endtask

  task automatic peek(string tag, logic [7:0] exp);
    rd_stat1 = 1'b1;
    #1 chk(tag, rd_val, exp);
    rd_stat1 = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    fe_ie = 1; pe_ie = 1;
    #1 chk("R1 irq after reset", {7'b0, err_irq}, 8'h00);
    chk("R9 idle read", rd_val, 8'h00);
    rd_pri("R1 primary after reset", 8'h00);
    rd_sec("R1 secondary after reset", 8'h00);

    // table walk: R2 R5 R6 R3
    for (int i = 0; i < NV; i++) begin
      fire(VEC[i][14:11]);
      {fe_ie, pe_ie} = VEC[i][10:9];
      #1 chk($sformatf("R5 irq vec %0d", i), {7'b0, err_irq}, {7'b0, VEC[i][0]});
      rd_pri($sformatf("R2 primary vec %0d", i), VEC[i][8:1]);
      rd_dat();
      peek($sformatf("R3 cleared vec %0d", i), 8'h00);
      rd_sec($sformatf("R6 break cleared vec %0d", i), 8'h00);
    end

    // R3 data read without prior primary read keeps flag
    fire(4'b0010);
    rd_dat();
    peek("R3 no clear without status read", 8'h02);
    rd_pri("R3 status read", 8'h02);
    rd_dat();
    peek("R3 clear after sequence", 8'h00);

    // R3 flag 0 at status read, set afterwards, stays
    rd_pri("R3 status read with none set", 8'h00);
    fire(4'b0001);
    rd_dat();
    peek("R3 unobserved flag stays", 8'h01);
    rd_pri("R3 arm", 8'h01);
    rd_dat();

    // R4 re-set between status and data read
    fire(4'b0010);
    rd_pri("R4 arm", 8'h02);
    fire(4'b0010);
    rd_dat();
    peek("R4 re-set between reads stays", 8'h02);
    rd_pri("R4 arm again", 8'h02);
    // R4 set in same cycle as qualifying data read
    rd_data = 1'b1; stop_zero_evt = 1'b1;
    tick();
    rd_data = 1'b0; stop_zero_evt = 1'b0;
    peek("R4 set wins over clear", 8'h02);
    rd_pri("R4 arm final", 8'h02);
    rd_dat();
    peek("R4 cleared at last", 8'h00);

    // R6 break: secondary shows break, irq only through framing enable
    fe_ie = 0; pe_ie = 0;
    fire(4'b0100);
    #1 chk("R5 break with enables off no irq", {7'b0, err_irq}, 8'h00);
    rd_sec("R6 break flag in secondary", 8'h02);
    rd_pri("R6 break forces fe and rdf", 8'h22);
    rd_dat();
    rd_sec("R6 break flag cleared", 8'h00);

    // R8 busy level live in secondary
    rx_busy = 1'b1;
    rd_sec("R8 busy bit", 8'h01);
    rx_busy = 1'b0;
    rd_sec("R8 busy released", 8'h00);

    // R9 priority when both status strobes are high
    fire(4'b0001);
    rx_busy = 1'b1;
    rd_stat1 = 1'b1; rd_stat2 = 1'b1;
    #1 chk("R9 primary has priority", rd_val, 8'h01);
    tick();
    rd_stat1 = 1'b0; rd_stat2 = 1'b0; rx_busy = 1'b0;
    rd_dat();

    // R7 ninth-bit clear pulse
    nine_bit_mode = 1'b1; break_evt = 1'b1;
    #1 chk("R7 pulse in nine-bit mode", {7'b0, ninth_clr}, 8'h01);
    tick();
    break_evt = 1'b0;
    #1 chk("R7 pulse ends", {7'b0, ninth_clr}, 8'h00);
    nine_bit_mode = 1'b0; break_evt = 1'b1;
    #1 chk("R7 no pulse in eight-bit mode", {7'b0, ninth_clr}, 8'h00);
    tick();
    break_evt = 1'b0;
    rd_pri("R7 arm", 8'h22);
    rd_dat();

    // R1 reset clears set flags
    fire(4'b1011);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    peek("R1 reset clears flags", 8'h00);
    rd_sec("R1 reset clears break", 8'h00);

    finish_run();
  end
endmodule